// File: doc/BRIEF.md
# Direct-Mapped Store-Policy Data Cache

This block sits between a processor's load/store port and a single-ported main memory. It keeps eight one-word lines, each with a valid flag, a dirty flag, a tag and a data word, and looks them up by the low bits of the word address. A build-time parameter chooses how write hits reach memory. In write-back mode a store only touches the line and marks it dirty, and the old contents go out to memory only when the line is displaced. In write-through mode every store is also sent to memory.

An ordinary store that misses claims its line, so a later load of that address hits. A store flagged non-temporal that misses goes straight to memory and leaves the array untouched. This suits streams of data that will not be read back soon.

The processor side holds one request at a time. A request is taken on a clock edge where `cpuValid` and `cpuReady` are both high. `cpuReady` returns high when the request has finished, and load data is valid on `cpuRdata` from then until the next request is taken. The memory side raises `memReq` with a stable command and keeps it up until `memDone` pulses for one cycle.

Top module: `dm_store_cache`

## Requirements
- R1: After reset every line is invalid and clean, `cpuReady` is high and `memReq` is low, so the first load of any address fetches from memory.
- R2: The 8-bit word address splits into a tag in bits 7:3 and a line index in bits 2:0. Memory addresses are word addresses in the same format, and addresses 0x07 and 0xFF map to distinct tags of the lowest-index and highest-index... specifically, 0xFF uses line 7 with tag 31 and 0x07 uses line 7 with tag 0.
- R3: In write-back mode a store hit updates only the line, sets its dirty flag and issues no memory command.
- R4: A load that hits returns the most recently stored value for that address without any memory command.
- R5: A miss whose victim is valid and dirty first writes the victim's data to memory at {victim tag, index}, and only then proceeds. For a load this means a memory read follows, giving exactly two commands; a fill read never starts while the victim is dirty.
- R6: A miss whose victim is clean or invalid issues no write-back. A load miss then issues exactly one memory read, and the fetched word is returned and installed.
- R7: In write-through mode every store, hit or miss, writes the word to memory, no line ever becomes dirty, and evictions never write back.
- R8: An ordinary store miss installs the line with the stored word, the valid flag and the new tag, without reading memory; a later load of that address hits.
- R9: A non-temporal store that misses issues exactly one memory write of the word at its own address and leaves every line unchanged.
- R10: A non-temporal store that hits behaves as an ordinary store hit under the selected policy (in write-back mode the line becomes dirty and is written back on eviction).
- R11: `memReq` stays high with unchanged `memWrite`, `memAddr` and `memWdata` until `memDone`. At most one command is outstanding at a time, and `cpuReady` is low whenever a command is outstanding.
- R12: Repeated stores to a line that is already dirty cause no memory command until that line is evicted, and the eviction carries the last stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpuValid | input | 1 | Processor request present |
| cpuWrite | input | 1 | Request is a store (0 = load) |
| cpuNonTemp | input | 1 | Store is non-temporal (no allocation on a miss) |
| cpuAddr | input | ADDR_W (8) | Word address of the request |
| cpuWdata | input | DATA_W (16) | Store data |
| cpuRdata | output | DATA_W (16) | Load result, valid while `cpuReady` is high after a load |
| cpuReady | output | 1 | Cache idle and able to take a request |
| memReq | output | 1 | Memory command outstanding |
| memWrite | output | 1 | Command is a write (0 = read) |
| memAddr | output | ADDR_W (8) | Memory word address |
| memWdata | output | DATA_W (16) | Memory write data |
| memRdata | input | DATA_W (16) | Memory read data, valid with `memDone` |
| memDone | input | 1 | One-cycle completion pulse for the command |

## Verification
The bench forces the corner cases where cache policies are usually wrong. A load that displaces a dirty line is one. A design that skips the write-back, or writes back to the new address instead of the old tag, makes the later reload return stale memory contents. A second case is a non-temporal store that misses: it must leave a dirty neighbour at the same index in place, and a design that allocates on it displaces that neighbour, which later reads and write-backs expose. A third is a non-temporal store that hits and then gets evicted: a design that treats the hit as a bypass leaves a stale copy, or never writes the word back. Every memory command is matched against an expected list in order. Any missing, extra or misaddressed write-back therefore shows up, as does a write-through store that fails to reach memory.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_MEMWR
  } cstate_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch a new processor request
    logic installCpu;  // write the stored word into the indexed line
    logic installMem;  // write the fetched word into the indexed line
    logic markDirty;   // dirty value used with installCpu
    logic cleanVictim; // clear dirty after a finished write-back
    logic rdFromLine;  // load result taken from the line
    logic rdFromMem;   // load result taken from memory
    logic selVictim;   // memory command carries the victim line
  } ctl_t;

endpackage

// File: rtl/dmc_datapath.sv
module dmc_datapath
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 3,
  parameter int DATA_W     = 16,
  parameter int WRITE_BACK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic              cpuWrite,
  input  logic              cpuNonTemp,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              reqWrite,
  output logic              reqNonTemp,
  output logic              hit,
  output logic              victimDirty,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata
);

  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int LINES = 1 << IDX_W;

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;

  logic [LINES-1:0]  validVec;
  logic [LINES-1:0]  dirtyVec;
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [DATA_W-1:0] dataArr [LINES];

  assign reqIdx = reqAddr[IDX_W-1:0];
  assign reqTag = reqAddr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr    <= '0;
      reqWdata   <= '0;
      reqWrite   <= 1'b0;
      reqNonTemp <= 1'b0;
    end else if (ctl.capture) begin
      reqAddr    <= cpuAddr;
      reqWdata   <= cpuWdata;
      reqWrite   <= cpuWrite;
      reqNonTemp <= cpuNonTemp;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              lineValid;
    logic              lineDirty;
    logic [TAG_W-1:0]  lineTag;
    logic [DATA_W-1:0] lineData;
    logic              lineSel;

    assign lineSel = (reqIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        lineValid <= 1'b0;
        lineDirty <= 1'b0;
        lineTag   <= '0;
        lineData  <= '0;
      end else if (lineSel) begin
        if (ctl.installCpu) begin
          lineValid <= 1'b1;
          lineDirty <= ctl.markDirty;
          lineTag   <= reqTag;
          lineData  <= reqWdata;
        end else if (ctl.installMem) begin
          lineValid <= 1'b1;
          lineDirty <= 1'b0;
          lineTag   <= reqTag;
          lineData  <= memRdata;
        end else if (ctl.cleanVictim) begin
          lineDirty <= 1'b0;
        end
      end
    end

    assign validVec[i] = lineValid;
    assign dirtyVec[i] = lineDirty;
    assign tagArr[i]   = lineTag;
    assign dataArr[i]  = lineData;
  end

  assign hit         = validVec[reqIdx] && (tagArr[reqIdx] == reqTag);
  assign victimDirty = validVec[reqIdx] && dirtyVec[reqIdx];
  assign memAddr     = ctl.selVictim ? {tagArr[reqIdx], reqIdx} : reqAddr;
  assign memWdata    = ctl.selVictim ? dataArr[reqIdx] : reqWdata;

  always_ff @(posedge clk) begin
    if (rst)                 cpuRdata <= '0;
    else if (ctl.rdFromLine) cpuRdata <= dataArr[reqIdx];
    else if (ctl.rdFromMem)  cpuRdata <= memRdata;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (validVec == '0 && dirtyVec == '0));

  // R7
  wt_never_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (WRITE_BACK != 0) || (dirtyVec == '0));

  // R9
  nt_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.installCpu |-> (hit || !reqNonTemp));

endmodule

// File: rtl/dmc_control.sv
module dmc_control
  import dmc_pkg::*;
#(
  parameter int WRITE_BACK = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cpuValid,
  input  logic hit,
  input  logic victimDirty,
  input  logic reqWrite,
  input  logic reqNonTemp,
  input  logic memDone,
  output ctl_t ctl,
  output logic cpuReady,
  output logic memReq,
  output logic memWrite
);

  localparam logic WB_MODE = (WRITE_BACK != 0);

  cstate_e state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    cpuReady  = 1'b0;
    memReq    = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpuReady = 1'b1;
        if (cpuValid) begin
          ctl.capture = 1'b1;
          nextState   = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          if (!reqWrite) begin
            ctl.rdFromLine = 1'b1;
            nextState      = ST_IDLE;
          end else begin
            ctl.installCpu = 1'b1;
            ctl.markDirty  = WB_MODE;
            nextState      = WB_MODE ? ST_IDLE : ST_MEMWR;
          end
        end else if (reqWrite && reqNonTemp) begin
          nextState = ST_MEMWR;
        end else if (victimDirty) begin
          nextState = ST_EVICT;
        end else if (reqWrite) begin
          ctl.installCpu = 1'b1;
          ctl.markDirty  = WB_MODE;
          nextState      = WB_MODE ? ST_IDLE : ST_MEMWR;
        end else begin
          nextState = ST_FILL;
        end
      end
      ST_EVICT: begin
        memReq        = 1'b1;
        memWrite      = 1'b1;
        ctl.selVictim = 1'b1;
        if (memDone) begin
          ctl.cleanVictim = 1'b1;
          nextState       = ST_LOOKUP;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memDone) begin
          ctl.installMem = 1'b1;
          ctl.rdFromMem  = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      ST_MEMWR: begin
        memReq   = 1'b1;
        memWrite = 1'b1;
        if (memDone) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memDone) |=> (memReq && $stable(memWrite)));

  // R11
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    memReq |-> !cpuReady);

endmodule

// File: rtl/dm_store_cache.sv
module dm_store_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int IDX_W      = 3,
  parameter int DATA_W     = 16,
  parameter int WRITE_BACK = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic              cpuNonTemp,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWdata,
  output logic [DATA_W-1:0] cpuRdata,
  output logic              cpuReady,
  output logic              memReq,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);

  ctl_t ctl;
  logic hit;
  logic victimDirty;
  logic reqWrite;
  logic reqNonTemp;

  dmc_control #(.WRITE_BACK(WRITE_BACK)) u_control (
    .clk        (clk),
    .rst        (rst),
    .cpuValid   (cpuValid),
    .hit        (hit),
    .victimDirty(victimDirty),
    .reqWrite   (reqWrite),
    .reqNonTemp (reqNonTemp),
    .memDone    (memDone),
    .ctl        (ctl),
    .cpuReady   (cpuReady),
    .memReq     (memReq),
    .memWrite   (memWrite)
  );

  dmc_datapath #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .DATA_W    (DATA_W),
    .WRITE_BACK(WRITE_BACK)
  ) u_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .cpuWrite   (cpuWrite),
    .cpuNonTemp (cpuNonTemp),
    .cpuAddr    (cpuAddr),
    .cpuWdata   (cpuWdata),
    .cpuRdata   (cpuRdata),
    .reqWrite   (reqWrite),
    .reqNonTemp (reqNonTemp),
    .hit        (hit),
    .victimDirty(victimDirty),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

  // R5
  no_fill_over_dirty_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memWrite) |-> !victimDirty);

  // R11
  cmd_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memDone) |=> ($stable(memAddr) && $stable(memWdata)));

endmodule

// File: tb/test_dm_store_cache.sv
module test_dm_store_cache;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        cpuValid   [2];
  logic        cpuWrite   [2];
  logic        cpuNonTemp [2];
  logic [7:0]  cpuAddr    [2];
  logic [15:0] cpuWdata   [2];
  logic [15:0] cpuRdata   [2];
  logic        cpuReady   [2];
  logic        memReq     [2];
  logic        memWrite   [2];
  logic [7:0]  memAddr    [2];
  logic [15:0] memWdata   [2];
  logic [15:0] memRdata   [2];
  logic        memDone    [2];

  dm_store_cache #(.WRITE_BACK(1)) i_dm_store_cache (
    .clk(clk), .rst(rst),
    .cpuValid(cpuValid[0]), .cpuWrite(cpuWrite[0]), .cpuNonTemp(cpuNonTemp[0]),
    .cpuAddr(cpuAddr[0]), .cpuWdata(cpuWdata[0]), .cpuRdata(cpuRdata[0]),
    .cpuReady(cpuReady[0]), .memReq(memReq[0]), .memWrite(memWrite[0]),
    .memAddr(memAddr[0]), .memWdata(memWdata[0]), .memRdata(memRdata[0]),
    .memDone(memDone[0])
  );

  dm_store_cache #(.WRITE_BACK(0)) i_dm_store_cache_wt (
    .clk(clk), .rst(rst),
    .cpuValid(cpuValid[1]), .cpuWrite(cpuWrite[1]), .cpuNonTemp(cpuNonTemp[1]),
    .cpuAddr(cpuAddr[1]), .cpuWdata(cpuWdata[1]), .cpuRdata(cpuRdata[1]),
    .cpuReady(cpuReady[1]), .memReq(memReq[1]), .memWrite(memWrite[1]),
    .memAddr(memAddr[1]), .memWdata(memWdata[1]), .memRdata(memRdata[1]),
    .memDone(memDone[1])
  );

  typedef struct {
    int       dut;
    bit       wr;
    bit [7:0] addr;
    bit [15:0] data;
    string    req;
  } txn_t;

  txn_t      expQ[$];
  bit [15:0] memArr [2][256];
  bit [15:0] arch   [2][256];
  int        lat    [2];
  int        checks = 0;
  int        errors = 0;

  function automatic bit [15:0] initWord(int a);
    return {8'hA5, 8'(a)};
  endfunction

  function automatic void check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  function automatic void expMem(int g, bit wr, bit [7:0] a, bit [15:0] d, string req);
    txn_t t;
    t.dut = g; t.wr = wr; t.addr = a; t.data = d; t.req = req;
    expQ.push_back(t);
  endfunction

  // memory model and scoreboard monitor, driven away from the active edge
  always @(negedge clk) begin
    for (int g = 0; g < 2; g++) begin
      if (memDone[g]) begin
        memDone[g] = 1'b0;
        lat[g] = 0;
      end else if (memReq[g]) begin
        lat[g]++;
        if (lat[g] == 2) begin
          check(!cpuReady[g], "R11", "ready while busy", int'(cpuReady[g]), 0);
          if (expQ.size() == 0) begin
            check(1'b0, "R3/R9/R12", "unexpected memory op addr", int'(memAddr[g]), 0);
          end else begin
            txn_t e;
            e = expQ.pop_front();
            check(e.dut == g && e.wr == memWrite[g] && e.addr == memAddr[g],
                  e.req, "memory op kind/addr", {int'(memWrite[g]), int'(memAddr[g])},
                  {int'(e.wr), int'(e.addr)});
            if (e.wr)
              check(memWdata[g] == e.data, e.req, "memory write data",
                    int'(memWdata[g]), int'(e.data));
          end
          if (memWrite[g]) memArr[g][memAddr[g]] = memWdata[g];
          else             memRdata[g] = memArr[g][memAddr[g]];
          memDone[g] = 1'b1;
        end
      end
    end
  end

  task automatic access(int g, bit wr, bit nt, bit [7:0] a, bit [15:0] d, string req);
    @(negedge clk);
    cpuValid[g] = 1'b1; cpuWrite[g] = wr; cpuNonTemp[g] = nt;
    cpuAddr[g] = a; cpuWdata[g] = d;
    @(negedge clk);
    cpuValid[g] = 1'b0;
    while (!cpuReady[g]) @(negedge clk);
    if (wr) arch[g][a] = d;
    else check(cpuRdata[g] == arch[g][a], req, "load data",
               int'(cpuRdata[g]), int'(arch[g][a]));
    check(expQ.size() == 0, req, "pending memory ops", expQ.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int g = 0; g < 2; g++) begin
      cpuValid[g] = 0; cpuWrite[g] = 0; cpuNonTemp[g] = 0;
      cpuAddr[g] = 0; cpuWdata[g] = 0; memRdata[g] = 0; memDone[g] = 0; lat[g] = 0;
      for (int a = 0; a < 256; a++) begin
        memArr[g][a] = initWord(a);
        arch[g][a]   = initWord(a);
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    for (int g = 0; g < 2; g++) begin
      check(cpuReady[g] == 1'b1, "R1", "ready after reset", int'(cpuReady[g]), 1);
      check(memReq[g] == 1'b0, "R1", "memReq after reset", int'(memReq[g]), 0);
    end

    // ---------- write-back instance ----------
    expMem(0, 0, 8'h11, 0, "R1_R6");  access(0, 0, 0, 8'h11, 0, "R1_R6");
    access(0, 0, 0, 8'h11, 0, "R4");
    access(0, 1, 0, 8'h11, 16'h1234, "R3");
    access(0, 0, 0, 8'h11, 0, "R4");
    access(0, 1, 0, 8'h11, 16'h5678, "R12");
    expMem(0, 1, 8'h11, 16'h5678, "R5"); expMem(0, 0, 8'h19, 0, "R5");
    access(0, 0, 0, 8'h19, 0, "R5");
    expMem(0, 0, 8'h11, 0, "R6");     access(0, 0, 0, 8'h11, 0, "R6");
    access(0, 1, 0, 8'h22, 16'hBEEF, "R8");
    access(0, 0, 0, 8'h22, 0, "R8");
    expMem(0, 1, 8'h2A, 16'hCAFE, "R9"); access(0, 1, 1, 8'h2A, 16'hCAFE, "R9");
    access(0, 0, 0, 8'h22, 0, "R9");
    expMem(0, 1, 8'h22, 16'hBEEF, "R9"); expMem(0, 0, 8'h2A, 0, "R9");
    access(0, 0, 0, 8'h2A, 0, "R9");
    access(0, 1, 1, 8'h2A, 16'h0F0F, "R10");
    access(0, 0, 0, 8'h2A, 0, "R10");
    expMem(0, 1, 8'h2A, 16'h0F0F, "R10"); expMem(0, 0, 8'h32, 0, "R10");
    access(0, 0, 0, 8'h32, 0, "R10");
    access(0, 1, 0, 8'h11, 16'h1111, "R12");
    expMem(0, 1, 8'h11, 16'h1111, "R5_R8"); access(0, 1, 0, 8'h09, 16'h2222, "R5_R8");
    access(0, 0, 0, 8'h09, 0, "R8");
    expMem(0, 0, 8'hFF, 0, "R2");     access(0, 0, 0, 8'hFF, 0, "R2");
    expMem(0, 0, 8'h07, 0, "R2");     access(0, 0, 0, 8'h07, 0, "R2");
    access(0, 0, 0, 8'h07, 0, "R2");

    // ---------- write-through instance ----------
    expMem(1, 0, 8'h05, 0, "R7");     access(1, 0, 0, 8'h05, 0, "R7");
    expMem(1, 1, 8'h05, 16'hAAAA, "R7"); access(1, 1, 0, 8'h05, 16'hAAAA, "R7");
    access(1, 0, 0, 8'h05, 0, "R7");
    expMem(1, 0, 8'h0D, 0, "R7");     access(1, 0, 0, 8'h0D, 0, "R7");
    expMem(1, 1, 8'h15, 16'hBBBB, "R7_R8"); access(1, 1, 0, 8'h15, 16'hBBBB, "R7_R8");
    access(1, 0, 0, 8'h15, 0, "R8");
    expMem(1, 1, 8'h1D, 16'hCCCC, "R9"); access(1, 1, 1, 8'h1D, 16'hCCCC, "R9");
    access(1, 0, 0, 8'h15, 0, "R9");
    expMem(1, 0, 8'h1D, 0, "R9");     access(1, 0, 0, 8'h1D, 0, "R9");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R11", "leftover memory ops", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule